// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash. Once software or a sequencer has written a program or erase command, a single `start` pulse hands control to this poller. It then decides when the embedded operation has finished by reading the device repeatedly and watching one status bit. That bit inverts on every read while the operation runs and holds still once the operation ends. Each read goes out as a request on a simple request/acknowledge bus. The 8-bit read data comes back in the cycle that the acknowledge is high.

The poller compares the watched bit across a pair of back-to-back reads. If the bit held steady, the operation is over. The poller reports pass, and the host may go back to ordinary array reads. If the bit changed and the timeout flag (bit 5) is low, the poller starts another pair of reads. If the bit changed and the timeout flag is high, the poller takes one more pair of reads to confirm. It does this because the toggling may have stopped just as the timeout flag rose. If the bit still changes in that confirming pair, the poller writes the reset command 0xF0 to put the device back into read mode, and then reports fail. A parameter selects which bit is watched, bit 6 or bit 2. An optional cap on the number of polling pairs forces a fail result, so a stuck device cannot hold the poller forever.

The states are IDLE, READ_A, READ_B, CONF_A, CONF_B, RESET_WR and DONE. The transitions are:
- IDLE goes to READ_A on `start`.
- READ_A goes to READ_B on acknowledge.
- READ_B goes to DONE (pass) when the watched bit is equal in both reads.
- READ_B goes to CONF_A when the bit differs and bit 5 is high.
- READ_B goes back to READ_A when the bit differs and bit 5 is low.
- READ_B goes to RESET_WR when the bit differs, bit 5 is low and the pair cap is reached.
- CONF_A goes to CONF_B on acknowledge.
- CONF_B goes to DONE (pass) when the bit is equal, or to RESET_WR when it differs.
- RESET_WR goes to DONE (fail) on acknowledge.
- DONE goes to IDLE after one cycle.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After reset, and while the poller is idle, `bus_req` and `done` are low.
- R2: A `start` pulse while idle begins a series of read transfers. Each transfer keeps `bus_req`, `bus_we` and `bus_wdata` steady until the cycle in which `bus_ack` is high. Reads have `bus_we` low.
- R3: If the watched bit (bit 6 when TOGGLE_SEL is 6, bit 2 when it is 2) has the same value in the first two reads, the poller reports pass after exactly two reads and makes no write.
- R4: If the watched bit differs within a pair and bit 5 of the second read of that pair is 0, the poller performs a fresh pair of reads and judges that pair the same way.
- R5: If the watched bit differs and bit 5 of the second read is 1, the poller performs exactly two more reads. If the watched bit is equal in those two reads, it reports pass with no write.
- R6: If the watched bit differs again in the confirming pair, the poller issues exactly one write, with `bus_we` high and `bus_wdata` = 0xF0, and then reports fail.
- R7: `done` is a one-cycle pulse. It rises only after the last transfer has been acknowledged and while `bus_req` is low. `pass_ok` is 1 with it for a pass and 0 for a fail.
- R8: With MAX_POLLS > 0, if MAX_POLLS pairs in a row differ with bit 5 low, the poller stops after 2*MAX_POLLS reads, issues the 0xF0 write and reports fail. MAX_POLLS = 0 removes the cap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins polling |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_we | output | 1 | 1 = write transfer, 0 = read |
| bus_wdata | output | 8 | Write data (reset command) |
| bus_ack | input | 1 | Transfer acknowledge; read data valid in this cycle |
| bus_rdata | input | 8 | Read data from the flash |
| done | output | 1 | One-cycle completion pulse |
| pass_ok | output | 1 | Result, valid with `done`: 1 pass, 0 fail |

## Verification
The bench models a device whose watched bit toggles for a chosen number of reads and whose bit 5 rises after another chosen number. Every other read bit carries random noise, so a poller that watches the wrong bit, or judges bit 5 from the wrong read, ends with the wrong read count or the wrong result. The directed cases cover:
- a finish on the very first pair;
- toggling that stops while bit 5 is still low;
- toggling that stops exactly as bit 5 rises, where a poller that skipped the confirming pair would wrongly report fail;
- toggling that continues through the confirming pair, where a poller that omitted the 0xF0 write or raised `done` before its acknowledge would be caught;
- a run that never stops, where a missing or off-by-one pair cap would show up in the read count.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    localparam int unsigned DATA_W      = 8;
    localparam int unsigned TIMEOUT_POS = 5;
    localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_A,
        ST_READ_B,
        ST_CONF_A,
        ST_CONF_B,
        ST_RESET_WR,
        ST_DONE
    } poll_state_t;
endpackage

// File: rtl/tbp_bit_pair.sv
module tbp_bit_pair
    import tbp_pkg::*;
#(
    parameter int unsigned TOGGLE_SEL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    output logic              differ,
    output logic              tflag
);
    logic first_q;
    logic cur_bit;

    generate
        if (TOGGLE_SEL == 2) begin : g_bit2
            assign cur_bit = rdata[2];
        end else begin : g_bit6
            assign cur_bit = rdata[6];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       first_q <= 1'b0;
        else if (capture) first_q <= cur_bit;
    end

    assign differ = first_q ^ cur_bit;
    assign tflag  = rdata[TIMEOUT_POS];
endmodule

// File: rtl/tbp_pair_limit.sv
module tbp_pair_limit #(
    parameter int unsigned MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    generate
        if (MAX_POLLS == 0) begin : g_nolimit
            assign at_limit = 1'b0;
        end else begin : g_limit
            localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   cnt_q <= '0;
                else if (clr) cnt_q <= '0;
                else if (inc) cnt_q <= cnt_q + 1'b1;
            end

            assign at_limit = (cnt_q == CNT_W'(MAX_POLLS - 1));
        end
    endgenerate
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl
    import tbp_pkg::*;
#(
    parameter int unsigned TOGGLE_SEL = 6,
    parameter int unsigned MAX_POLLS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              pass_ok
);
    poll_state_t state_q, state_d;
    logic pass_q, pass_d;
    logic differ, tflag, at_limit;
    logic capture, pair_inc, pair_clr;

    assign capture  = bus_ack && (state_q == ST_READ_A || state_q == ST_CONF_A);
    assign pair_inc = bus_ack && state_q == ST_READ_B && differ && !tflag;
    assign pair_clr = start && state_q == ST_IDLE;

    tbp_bit_pair #(.TOGGLE_SEL(TOGGLE_SEL)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rdata   (bus_rdata),
        .differ  (differ),
        .tflag   (tflag)
    );

    tbp_pair_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pair_clr),
        .inc      (pair_inc),
        .at_limit (at_limit)
    );

    always_comb begin
        state_d = state_q;
        pass_d  = pass_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_READ_A;
                pass_d  = 1'b0;
            end
            ST_READ_A: if (bus_ack) state_d = ST_READ_B;
            ST_READ_B: if (bus_ack) begin
                if (!differ) begin
                    state_d = ST_DONE;
                    pass_d  = 1'b1;
                end else if (tflag) begin
                    state_d = ST_CONF_A;
                end else if (at_limit) begin
                    state_d = ST_RESET_WR;
                end else begin
                    state_d = ST_READ_A;
                end
            end
            ST_CONF_A: if (bus_ack) state_d = ST_CONF_B;
            ST_CONF_B: if (bus_ack) begin
                if (!differ) begin
                    state_d = ST_DONE;
                    pass_d  = 1'b1;
                end else begin
                    state_d = ST_RESET_WR;
                end
            end
            ST_RESET_WR: if (bus_ack) begin
                state_d = ST_DONE;
                pass_d  = 1'b0;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            ST_READ_A, ST_READ_B, ST_CONF_A, ST_CONF_B: bus_req = 1'b1;
            ST_RESET_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = RESET_CMD;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign pass_ok = pass_q;
endmodule

// File: rtl/tbp_poll_ctrl_checker.sv
module tbp_poll_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bus_req,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       bus_ack,
    input logic       done,
    input logic       pass_ok
);
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               wrote_q <= 1'b0;
        else if (start && !bus_req)               wrote_q <= 1'b0;
        else if (bus_req && bus_we && bus_ack)    wrote_q <= 1'b1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!bus_req && !done));

    assert_hold_until_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));

    assert_reset_cmd_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_wdata == 8'hF0));

    assert_fail_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass_ok) |-> wrote_q);

    assert_pass_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass_ok) |-> !wrote_q);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);
endmodule

bind tbp_poll_ctrl tbp_poll_ctrl_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .pass_ok   (pass_ok)
);

// File: tb/test_tbp_poll_ctrl.sv
`timescale 1ns/1ps
module test_tbp_poll_ctrl;
    localparam int MAXP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       bus_req, bus_we, done, pass_ok;
    logic [7:0] bus_wdata;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int dev_n = 0;
    int dev_k = 0;
    int read_cnt = 0;
    int write_cnt = 0;
    logic [7:0] last_wdata = 8'h00;
    int lat_left = 0;

    always #5 clk = ~clk;

    tbp_poll_ctrl #(.TOGGLE_SEL(6), .MAX_POLLS(MAXP)) i_tbp_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .pass_ok(pass_ok)
    );

    function automatic logic [7:0] dev_read(int i);
        logic [7:0] r;
        int m;
        r = 8'($urandom);
        m = (i < dev_n) ? i : dev_n;
        r[6] = m[0];
        r[5] = (i >= dev_k);
        return r;
    endfunction

    // Expected outcome from the requirements: pass, number of reads
    task automatic expect_run(input int n, input int k, output bit ep, output int er);
        int i = 0;
        int pairs = 0;
        forever begin
            if (i >= n) begin ep = 1; er = i + 2; return; end
            if ((i + 1) >= k) begin
                ep = ((i + 2) >= n);
                er = i + 4;
                return;
            end
            pairs++;
            if (pairs >= MAXP) begin ep = 0; er = i + 2; return; end
            i += 2;
        end
    endtask

    // Bus slave model
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (lat_left > 0) lat_left--;
                else begin
                    if (bus_we) begin
                        write_cnt++;
                        last_wdata = bus_wdata;
                    end else begin
                        bus_rdata = dev_read(read_cnt);
                        read_cnt++;
                    end
                    bus_ack = 1'b1;
                    lat_left = $urandom % 3;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input int n, input int k, input string req);
        bit ep;
        int er;
        int w;
        bit got_done;
        dev_n = n; dev_k = k;
        read_cnt = 0; write_cnt = 0; last_wdata = 8'h00;
        expect_run(n, k, ep, er);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 0;
        w = 0;
        while (!got_done && w < 2000) begin
            @(negedge clk);
            if (done) got_done = 1;
            w++;
        end
        check(got_done, {req, " done seen"}, int'(got_done), 1);
        check(pass_ok == ep, {req, " pass_ok"}, int'(pass_ok), int'(ep));
        check(read_cnt == er, {req, " read count"}, read_cnt, er);
        check(write_cnt == (ep ? 0 : 1), {req, " write count R6"}, write_cnt, ep ? 0 : 1);
        if (!ep) check(last_wdata == 8'hF0, "R6 reset data", int'(last_wdata), 8'hF0);
        @(negedge clk);
        check(!done, "R7 done one cycle", int'(done), 0);
        check(!bus_req, "R1 idle after op", int'(bus_req), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!bus_req && !done, "R1 reset state", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !done, "R1 after reset release", int'(done), 0);

        run_op(0, 99, "R3 first pair steady");
        run_op(2, 99, "R4 second pair steady");
        run_op(2, 0, "R5 stops at timeout");
        run_op(3, 1, "R6 still toggling");
        run_op(1000, 1000, "R8 pair cap");
        run_op(5, 3, "R5 R6 late timeout");

        for (int t = 0; t < 30; t++) begin
            run_op(int'($urandom % 22), int'($urandom % 22), "R2 R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule